// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This block settles control flow for one instruction at a time. The decoder gives it an operation code and the operands that matter: the current program counter, a relative offset, the status byte, a bit that has already been tested, an equality result, a flag that says whether the following instruction takes two words, and the return address popped off the stack. The block decides whether control leaves the sequential path. It produces the next program counter and the number of clock cycles the instruction occupies, and it raises a one-cycle request to set the interrupt-enable flag when an interrupt return completes.

Outputs are registered, so every result appears one clock after the inputs that produced it. The status byte uses a fixed layout: carry in bit 0, zero in 1, negative in 2, overflow in 3, sign in 4, half-carry in 5, transfer bit in 6 and interrupt enable in 7. The unit does not read bit 4. It derives the sign condition from bits 2 and 3, so signed comparisons stay correct even when the stored copy is stale. Unsigned aliases (same-or-higher and lower) are branch-if-clear and branch-if-set on bit 0. Equal and not-equal are the same two operations on bit 1.

Top module: `bsu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs go to zero: `npc_o`=0, `taken_o`=0, `cyc_o`=0 and `iset_o`=0. Out of reset, every output reflects the inputs sampled at the previous rising edge.
- R2: Operation code 0, and every unused code from 10 to 15, gives `npc_o` = PC+1, `taken_o`=0 and `cyc_o`=1.
- R3: Code 1 (branch if set) and code 2 (branch if clear) test status bit `sel_i`. When the branch is taken, `npc_o` = PC+offset+1, `taken_o`=1 and `cyc_o`=2. When it is not taken, `npc_o` = PC+1, `taken_o`=0 and `cyc_o`=1.
- R4: With `sel_i`=4, the tested bit is N XOR V, taken from bits 2 and 3. The value of `sreg_i[4]` has no effect.
- R5: The offset is treated as a signed OFS_W-bit value. All program counter arithmetic wraps modulo 2^PC_W.
- R6: Code 3 (relative jump) always transfers to PC+offset+1, with `taken_o`=1 and `cyc_o`=2.
- R7: Code 4 (relative call) transfers to the same target as code 3, with `taken_o`=1 and `cyc_o`=3.
- R8: Code 5 (return) and code 6 (interrupt return) load `npc_o` from `ret_addr_i`, with `taken_o`=1 and `cyc_o`=4. Only code 6 raises `iset_o`, and only for that one cycle.
- R9: Code 7 skips when `eq_i`=1, code 8 skips when `bit_i`=0 and code 9 skips when `bit_i`=1. A skip gives `npc_o` = PC+2 if `next_two_i`=0 and PC+3 if `next_two_i`=1, with `taken_o`=1 and `cyc_o`=2. When there is no skip, the result is PC+1, `taken_o`=0 and `cyc_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| pc_i | input | PC_W | Current program counter |
| offs_i | input | OFS_W | Signed relative offset |
| sreg_i | input | 8 | Status byte |
| sel_i | input | 3 | Status bit selector for conditional branches |
| bit_i | input | 1 | Pre-tested bit for bit skips |
| eq_i | input | 1 | Equality result for compare-skip |
| next_two_i | input | 1 | Following instruction is two words long |
| ret_addr_i | input | PC_W | Address popped from the stack |
| npc_o | output | PC_W | Next program counter |
| taken_o | output | 1 | Control left the sequential path |
| cyc_o | output | 3 | Cycles the instruction occupies |
| iset_o | output | 1 | One-cycle request to set interrupt enable |

## Verification
The bench targets the signed branch with a status byte whose bit 4 disagrees with N XOR V. A unit that read the stored bit would branch the wrong way. It also drives negative offsets at address 0 and a skip across the top of memory. These catch a missing sign extension or a missing wrap, which would show up as a far-off target. Skips are driven with both next-word lengths, so a fixed skip distance fails on two-word instructions. The bench follows each interrupt return with a plain return, so an interrupt-enable pulse that lingers, or that also fires on a plain return, is exposed.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    // operation codes
    localparam logic [3:0] OPC_NONE  = 4'd0;
    localparam logic [3:0] OPC_BRSET = 4'd1;
    localparam logic [3:0] OPC_BRCLR = 4'd2;
    localparam logic [3:0] OPC_JMP   = 4'd3;
    localparam logic [3:0] OPC_CALL  = 4'd4;
    localparam logic [3:0] OPC_RET   = 4'd5;
    localparam logic [3:0] OPC_IRET  = 4'd6;
    localparam logic [3:0] OPC_SKEQ  = 4'd7;
    localparam logic [3:0] OPC_SKBC  = 4'd8;
    localparam logic [3:0] OPC_SKBS  = 4'd9;

    // status byte positions
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;

    // cycle counts per class
    localparam logic [2:0] CYC_ONE  = 3'd1;
    localparam logic [2:0] CYC_TWO  = 3'd2;
    localparam logic [2:0] CYC_CALL = 3'd3;
    localparam logic [2:0] CYC_RET  = 3'd4;

    typedef enum logic [1:0] {
        SRC_SEQ  = 2'd0,
        SRC_REL  = 2'd1,
        SRC_SKIP = 2'd2,
        SRC_STK  = 2'd3
    } src_e;

    typedef struct packed {
        logic       taken;
        logic [2:0] cyc;
        src_e       src;
        logic       iset;
    } xfer_t;

    function automatic xfer_t mk_xfer(input logic tk, input logic [2:0] cy,
                                      input src_e sr, input logic is);
        xfer_t r;
        r.taken = tk;
        r.cyc   = cy;
        r.src   = sr;
        r.iset  = is;
        return r;
    endfunction

    // conditional outcome: taken -> given source, two cycles; else sequential
    function automatic xfer_t mk_cond(input logic hit, input src_e sr);
        return hit ? mk_xfer(1'b1, CYC_TWO, sr, 1'b0)
                   : mk_xfer(1'b0, CYC_ONE, SRC_SEQ, 1'b0);
    endfunction

endpackage

// File: rtl/bsu_cond.sv
module bsu_cond
    import ctl_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic [7:0] sreg_i,
    input  logic [2:0] sel_i,
    input  logic       bit_i,
    input  logic       eq_i,
    output xfer_t      dec_o
);
    logic [7:0] flags_eff;
    logic       tested;

    // sign condition is rebuilt from N and V; stored copy is not trusted
    always_comb begin
        flags_eff        = sreg_i;
        flags_eff[FLG_S] = sreg_i[FLG_N] ^ sreg_i[FLG_V];
    end

    assign tested = flags_eff[sel_i];

    always_comb begin
        unique case (op_i)
            OPC_BRSET: dec_o = mk_cond(tested, SRC_REL);
            OPC_BRCLR: dec_o = mk_cond(!tested, SRC_REL);
            OPC_JMP:   dec_o = mk_xfer(1'b1, CYC_TWO, SRC_REL, 1'b0);
            OPC_CALL:  dec_o = mk_xfer(1'b1, CYC_CALL, SRC_REL, 1'b0);
            OPC_RET:   dec_o = mk_xfer(1'b1, CYC_RET, SRC_STK, 1'b0);
            OPC_IRET:  dec_o = mk_xfer(1'b1, CYC_RET, SRC_STK, 1'b1);
            OPC_SKEQ:  dec_o = mk_cond(eq_i, SRC_SKIP);
            OPC_SKBC:  dec_o = mk_cond(!bit_i, SRC_SKIP);
            OPC_SKBS:  dec_o = mk_cond(bit_i, SRC_SKIP);
            default:   dec_o = mk_xfer(1'b0, CYC_ONE, SRC_SEQ, 1'b0);
        endcase
    end
endmodule

// File: rtl/bsu_target.sv
module bsu_target
    import ctl_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int OFS_W = 12
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFS_W-1:0] offs_i,
    input  logic [PC_W-1:0]  ret_i,
    input  logic             two_i,
    input  src_e             src_i,
    output logic [PC_W-1:0]  npc_o
);
    localparam int EXT_W = (PC_W > OFS_W) ? (PC_W - OFS_W) : 1;

    logic [PC_W-1:0] offs_x;
    logic [PC_W-1:0] skip_d;

    generate
        if (OFS_W >= PC_W) begin : g_trunc
            // upper bits vanish in modulo arithmetic
            assign offs_x = offs_i[PC_W-1:0];
        end else begin : g_sext
            assign offs_x = {{EXT_W{offs_i[OFS_W-1]}}, offs_i};
        end
    endgenerate

    assign skip_d = two_i ? PC_W'(3) : PC_W'(2);

    always_comb begin
        unique case (src_i)
            SRC_REL:  npc_o = pc_i + offs_x + PC_W'(1);
            SRC_SKIP: npc_o = pc_i + skip_d;
            SRC_STK:  npc_o = ret_i;
            default:  npc_o = pc_i + PC_W'(1);
        endcase
    end
endmodule

// File: rtl/bsu_top.sv
module bsu_top
    import ctl_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFS_W-1:0] offs_i,
    input  logic [7:0]       sreg_i,
    input  logic [2:0]       sel_i,
    input  logic             bit_i,
    input  logic             eq_i,
    input  logic             next_two_i,
    input  logic [PC_W-1:0]  ret_addr_i,
    output logic [PC_W-1:0]  npc_o,
    output logic             taken_o,
    output logic [2:0]       cyc_o,
    output logic             iset_o
);
    xfer_t           dec;
    logic [PC_W-1:0] npc_c;

    bsu_cond u_cond (
        .op_i   (op_i),
        .sreg_i (sreg_i),
        .sel_i  (sel_i),
        .bit_i  (bit_i),
        .eq_i   (eq_i),
        .dec_o  (dec)
    );

    bsu_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
        .pc_i   (pc_i),
        .offs_i (offs_i),
        .ret_i  (ret_addr_i),
        .two_i  (next_two_i),
        .src_i  (dec.src),
        .npc_o  (npc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            npc_o   <= '0;
            taken_o <= 1'b0;
            cyc_o   <= 3'd0;
            iset_o  <= 1'b0;
        end else begin
            npc_o   <= npc_c;
            taken_o <= dec.taken;
            cyc_o   <= dec.cyc;
            iset_o  <= dec.iset;
        end
    end

    // R2: idle code gives the sequential successor in one cycle
    a_r2_seq_default: assert property (@(posedge clk) disable iff (rst)
        (op_i == OPC_NONE) |=> (npc_o == $past(pc_i) + PC_W'(1) && !taken_o && cyc_o == 3'd1));

    // R6: relative jump always taken, two cycles
    a_r6_jump_cycles: assert property (@(posedge clk) disable iff (rst)
        (op_i == OPC_JMP) |=> (taken_o && cyc_o == 3'd2));

    // R8: both returns take the popped address in four cycles
    a_r8_return_addr: assert property (@(posedge clk) disable iff (rst)
        (op_i == OPC_RET || op_i == OPC_IRET) |=> (npc_o == $past(ret_addr_i) && cyc_o == 3'd4));

    // R8: interrupt-enable request only after an interrupt return
    a_r8_iset_source: assert property (@(posedge clk) disable iff (rst)
        iset_o |-> ($past(op_i) == OPC_IRET));

    // R9: skip distance follows the next-word length
    a_r9_skip_dist: assert property (@(posedge clk) disable iff (rst)
        (op_i == OPC_SKEQ || op_i == OPC_SKBC || op_i == OPC_SKBS) |=>
        (taken_o ? (PC_W'(npc_o - $past(pc_i)) == ($past(next_two_i) ? PC_W'(3) : PC_W'(2)))
                 : (PC_W'(npc_o - $past(pc_i)) == PC_W'(1))));
endmodule

// File: tb/sim_bsu_top.sv
`timescale 1ns/1ps
module sim_bsu_top;
    localparam int PC_W  = 9;
    localparam int OFS_W = 12;
    localparam int PMASK = (1 << PC_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       op_i = '0;
    logic [PC_W-1:0]  pc_i = '0;
    logic [OFS_W-1:0] offs_i = '0;
    logic [7:0]       sreg_i = '0;
    logic [2:0]       sel_i = '0;
    logic             bit_i = 1'b0;
    logic             eq_i = 1'b0;
    logic             next_two_i = 1'b0;
    logic [PC_W-1:0]  ret_addr_i = '0;
    logic [PC_W-1:0]  npc_o;
    logic             taken_o;
    logic [2:0]       cyc_o;
    logic             iset_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bsu_top #(.PC_W(PC_W), .OFS_W(OFS_W)) u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .pc_i(pc_i), .offs_i(offs_i),
        .sreg_i(sreg_i), .sel_i(sel_i), .bit_i(bit_i), .eq_i(eq_i),
        .next_two_i(next_two_i), .ret_addr_i(ret_addr_i),
        .npc_o(npc_o), .taken_o(taken_o), .cyc_o(cyc_o), .iset_o(iset_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op, input int sel);
        if (op == 1 || op == 2) return (sel == 4) ? "R4" : "R3";
        if (op == 3) return "R6";
        if (op == 4) return "R7";
        if (op == 5 || op == 6) return "R8";
        if (op >= 7 && op <= 9) return "R9";
        return "R2";
    endfunction

    // behavioural reference
    task automatic model(input int op, pc, offs, sreg, sel, b, eq, two, ra,
                         output int e_npc, output int e_tk, output int e_cyc, output int e_is);
        int so, flag, hit;
        so = (offs >= (1 << (OFS_W-1))) ? offs - (1 << OFS_W) : offs;
        if (sel == 4) flag = ((sreg >> 2) ^ (sreg >> 3)) & 1;
        else          flag = (sreg >> sel) & 1;
        e_npc = (pc + 1) & PMASK; e_tk = 0; e_cyc = 1; e_is = 0;
        case (op)
            1, 2: begin
                hit = (op == 1) ? flag : !flag;
                if (hit) begin e_npc = (pc + so + 1) & PMASK; e_tk = 1; e_cyc = 2; end
            end
            3: begin e_npc = (pc + so + 1) & PMASK; e_tk = 1; e_cyc = 2; end
            4: begin e_npc = (pc + so + 1) & PMASK; e_tk = 1; e_cyc = 3; end
            5: begin e_npc = ra; e_tk = 1; e_cyc = 4; end
            6: begin e_npc = ra; e_tk = 1; e_cyc = 4; e_is = 1; end
            7, 8, 9: begin
                hit = (op == 7) ? eq : ((op == 8) ? !b : b);
                if (hit) begin e_npc = (pc + (two ? 3 : 2)) & PMASK; e_tk = 1; e_cyc = 2; end
            end
            default: ;
        endcase
    endtask

    task automatic step(input int op, pc, offs, sreg, sel, b, eq, two, ra, input string tag);
        int e_npc, e_tk, e_cyc, e_is;
        @(negedge clk);
        op_i = 4'(op); pc_i = PC_W'(pc); offs_i = OFS_W'(offs); sreg_i = 8'(sreg);
        sel_i = 3'(sel); bit_i = b[0]; eq_i = eq[0]; next_two_i = two[0]; ret_addr_i = PC_W'(ra);
        model(op, pc & PMASK, offs & ((1 << OFS_W) - 1), sreg, sel, b, eq, two, ra & PMASK,
              e_npc, e_tk, e_cyc, e_is);
        @(posedge clk);
        #1;
        check(int'(npc_o) == e_npc, tag, "npc", int'(npc_o), e_npc);
        check(int'(taken_o) == e_tk, tag, "taken", int'(taken_o), e_tk);
        check(int'(cyc_o) == e_cyc, tag, "cycles", int'(cyc_o), e_cyc);
        check(int'(iset_o) == e_is, tag, "iset", int'(iset_o), e_is);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(npc_o == '0, "R1", "reset npc", int'(npc_o), 0);
        check(!taken_o, "R1", "reset taken", int'(taken_o), 0);
        check(cyc_o == 3'd0, "R1", "reset cycles", int'(cyc_o), 0);
        check(!iset_o, "R1", "reset iset", int'(iset_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: idle and unused codes
        step(0, 5, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(13, 77, 9, 8'hFF, 1, 1, 1, 1, 3, "R2");
        step(15, 200, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R3: branch on zero and carry
        step(1, 100, 10, 8'h02, 1, 0, 0, 0, 0, "R3");
        step(1, 100, 10, 8'h00, 1, 0, 0, 0, 0, "R3");
        step(2, 40, 3, 8'h00, 0, 0, 0, 0, 0, "R3");
        step(2, 40, 3, 8'h01, 0, 0, 0, 0, 0, "R3");
        // R4: signed condition ignores stored bit 4
        step(1, 60, 20, 8'h1C, 4, 0, 0, 0, 0, "R4");
        step(1, 60, 20, 8'h04, 4, 0, 0, 0, 0, "R4");
        step(2, 60, 20, 8'h10, 4, 0, 0, 0, 0, "R4");
        step(2, 60, 20, 8'h08, 4, 0, 0, 0, 0, "R4");
        // R5: sign extension and wrap
        step(3, 0, 12'hFFF, 0, 0, 0, 0, 0, 0, "R5");
        step(3, 3, 12'hFFB, 0, 0, 0, 0, 0, 0, "R5");
        step(0, 511, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(7, 510, 0, 0, 0, 0, 1, 1, 0, "R5");
        step(4, 500, 30, 0, 0, 0, 0, 0, 0, "R5");
        // R6, R7
        step(3, 128, 64, 0, 0, 0, 0, 0, 0, "R6");
        step(4, 128, 64, 0, 0, 0, 0, 0, 0, "R7");
        step(4, 20, 12'hFF0, 0, 0, 0, 0, 0, 0, "R7");
        // R8: returns and the interrupt-enable pulse
        step(6, 9, 0, 0, 0, 0, 0, 0, 321, "R8");
        step(5, 9, 0, 0, 0, 0, 0, 0, 123, "R8");
        step(6, 9, 0, 0, 0, 0, 0, 0, 7, "R8");
        step(0, 9, 0, 0, 0, 0, 0, 0, 7, "R8");
        // R9: skips with both next-word lengths
        step(7, 50, 0, 0, 0, 0, 1, 0, 0, "R9");
        step(7, 50, 0, 0, 0, 0, 1, 1, 0, "R9");
        step(7, 50, 0, 0, 0, 0, 0, 1, 0, "R9");
        step(8, 50, 0, 0, 0, 0, 0, 1, 0, "R9");
        step(8, 50, 0, 0, 0, 1, 0, 1, 0, "R9");
        step(9, 50, 0, 0, 0, 1, 0, 0, 0, "R9");
        step(9, 50, 0, 0, 0, 0, 0, 0, 0, "R9");

        // mixed traffic compared on every clock
        for (int i = 0; i < 600; i++) begin
            int op, sel;
            op  = $urandom_range(0, 15);
            sel = $urandom_range(0, 7);
            step(op, $urandom_range(0, PMASK), $urandom_range(0, (1 << OFS_W) - 1),
                 $urandom_range(0, 255), sel, $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, PMASK), tag_of(op, sel));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule